// File: doc/BRIEF.md
# UART Receiver with Start Validation

This block is the receive half of an asynchronous serial port. The serial input passes through a two-flop synchroniser. A receive state machine then counts a free-running enable that ticks sixteen times per bit period. After a falling edge on the line, the machine waits eight ticks and checks the start bit again. A start bit that has already gone high by then is treated as noise. Once the start bit is accepted, each following bit is sampled at its centre, every sixteen ticks.

Each finished character is written into a 16-entry first-in-first-out queue together with three status flags: framing error, parity error and break. The word length, parity enable and parity sense come from line-control inputs that the owner keeps steady while a character is on the line. A consumer reads the head of the queue directly and pops it with a one-cycle read strobe. If a character completes while the queue is full, that character is dropped and a sticky overrun flag is set.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `empty_o` is 1, `full_o` is 0 and `overrun_o` is 0.
- R2: A low level on the synchronised line starts a character only if the line is still low at the 8th tick of `baud16_en_i`. Otherwise nothing is stored and the receiver is ready for the next start at once.
- R3: Data bits are sampled every 16 ticks after the start check, least significant bit first. `word_len_i` gives the count: 0=5, 1=6, 2=7, 3=8 bits. Bits above the word length read as zero.
- R4: When `par_en_i` is 1, one parity bit follows the data. With `par_odd_i`=1 the data and parity bit together must hold an odd number of ones, and with 0 an even number. A mismatch sets the parity-error flag. When `par_en_i` is 0 no parity bit is expected and the flag is 0.
- R5: A stop bit sampled low sets the framing-error flag of that character.
- R6: If every data bit, the parity bit (when enabled) and the stop bit are all sampled low, the break flag is set. The framing-error flag is set as well.
- R7: After a framing error, no new start bit is accepted until the line has been seen high.
- R8: The queue holds 16 characters and returns them in arrival order. The outputs `rd_*` show the oldest entry while `empty_o` is 0, and `rd_en_i` removes it. `full_o` is 1 when 16 entries are held.
- R9: A character that completes while the queue is full and no read is made is discarded. `overrun_o` is then set and stays set until reset.
- R10: A character that completes in the same cycle as a read of a full queue is stored. `overrun_o` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| baud16_en_i | input | 1 | Sixteen-per-bit sampling enable |
| word_len_i | input | 2 | Data bits minus five |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| rd_en_i | input | 1 | Pop the head entry |
| rd_data_o | output | 8 | Head entry data |
| rd_frm_err_o | output | 1 | Head entry framing error |
| rd_par_err_o | output | 1 | Head entry parity error |
| rd_brk_o | output | 1 | Head entry break |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| overrun_o | output | 1 | Sticky character-lost flag |

## Verification
The write of a finished character and a read strobe can land on the same clock edge. This matters most when the queue is full, because the outcome decides between storing the character and declaring an overrun. The bench first measures, at the ports, how many cycles pass from the start edge to the moment the queue stops reading empty. It then fills the queue and places a single read strobe on exactly that edge for a new character. The case passes if `full_o` stays 1, `overrun_o` stays 0, and the new character drains last, after the 15 older entries that remain.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef struct packed {
      logic       brk;
      logic       par_err;
      logic       frm_err;
      logic [7:0] data;
   } rx_char_t;

   localparam int unsigned CHAR_W = $bits(rx_char_t);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_WAITHI
   } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("uart_rx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '1;
      else         sr_q <= {sr_q[STAGES-2:0], d_i};
   end

   assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int unsigned OVS = 16,
   parameter int unsigned MID = 8
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       rxd_s_i,
   input  logic       tick_i,
   input  logic [1:0] word_len_i,
   input  logic       par_en_i,
   input  logic       par_odd_i,
   output logic       push_o,
   output rx_char_t   char_o
);
   localparam int unsigned CW = $clog2(OVS);

   if (OVS < 4 || MID == 0 || MID >= OVS) begin : g_bad_ovs
      $error("uart_rx_frame: need OVS >= 4 and 0 < MID < OVS");
   end

   rx_state_e   state_q;
   logic [CW-1:0] cnt_q;
   logic [2:0]  idx_q;
   logic [7:0]  shr_q;
   logic        pbit_q;
   logic [2:0]  last_idx;
   logic        mid_hit;
   logic        bit_hit;

   assign last_idx = 3'd4 + {1'b0, word_len_i};
   assign mid_hit  = tick_i && (cnt_q == CW'(MID - 1));
   assign bit_hit  = tick_i && (cnt_q == CW'(OVS - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         shr_q   <= '0;
         pbit_q  <= 1'b0;
         push_o  <= 1'b0;
         char_o  <= '0;
      end else begin
         push_o <= 1'b0;
         if (tick_i && state_q != ST_IDLE && state_q != ST_WAITHI)
            cnt_q <= (mid_hit && state_q == ST_START) || bit_hit ? '0 : cnt_q + 1'b1;
         unique case (state_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (!rxd_s_i) state_q <= ST_START;
            end
            ST_START: if (mid_hit) begin
               if (rxd_s_i) state_q <= ST_IDLE;
               else begin
                  state_q <= ST_DATA;
                  idx_q   <= '0;
                  shr_q   <= '0;
                  pbit_q  <= 1'b0;
               end
            end
            ST_DATA: if (bit_hit) begin
               shr_q[idx_q] <= rxd_s_i;
               if (idx_q == last_idx) state_q <= par_en_i ? ST_PAR : ST_STOP;
               else                   idx_q   <= idx_q + 1'b1;
            end
            ST_PAR: if (bit_hit) begin
               pbit_q  <= rxd_s_i;
               state_q <= ST_STOP;
            end
            ST_STOP: if (bit_hit) begin
               push_o         <= 1'b1;
               char_o.data    <= shr_q;
               char_o.frm_err <= !rxd_s_i;
               char_o.par_err <= par_en_i && ((^shr_q ^ pbit_q) != par_odd_i);
               char_o.brk     <= !rxd_s_i && (shr_q == 8'h00) && !(par_en_i && pbit_q);
               state_q        <= rxd_s_i ? ST_IDLE : ST_WAITHI;
            end
            ST_WAITHI: if (rxd_s_i) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned W     = 11
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         push_i,
   input  logic [W-1:0] wdata_i,
   input  logic         pop_i,
   output logic [W-1:0] rdata_o,
   output logic         empty_o,
   output logic         full_o,
   output logic         overrun_o
);
   localparam int unsigned AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("uart_rx_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [AW:0]   cnt_q;
   logic          do_pop, do_push;

   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == (AW+1)'(DEPTH));
   assign do_pop  = pop_i && !empty_o;
   assign do_push = push_i && (!full_o || do_pop);
   assign rdata_o = mem_q[rp_q];

   always_ff @(posedge clk_i) begin
      if (do_push) mem_q[wp_q] <= wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wp_q      <= '0;
         rp_q      <= '0;
         cnt_q     <= '0;
         overrun_o <= 1'b0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
         if (push_i && !do_push) overrun_o <= 1'b1;
      end
   end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_rx_pkg::*;
#(
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned OVS         = 16,
   parameter int unsigned MID         = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       rxd_i,
   input  logic       baud16_en_i,
   input  logic [1:0] word_len_i,
   input  logic       par_en_i,
   input  logic       par_odd_i,
   input  logic       rd_en_i,
   output logic [7:0] rd_data_o,
   output logic       rd_frm_err_o,
   output logic       rd_par_err_o,
   output logic       rd_brk_o,
   output logic       empty_o,
   output logic       full_o,
   output logic       overrun_o
);
   logic     rxd_s;
   logic     chr_push;
   rx_char_t chr_new;
   rx_char_t chr_head;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (rxd_i),
      .q_o   (rxd_s)
   );

   uart_rx_frame #(.OVS(OVS), .MID(MID)) frame_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rxd_s_i   (rxd_s),
      .tick_i    (baud16_en_i),
      .word_len_i(word_len_i),
      .par_en_i  (par_en_i),
      .par_odd_i (par_odd_i),
      .push_o    (chr_push),
      .char_o    (chr_new)
   );

   uart_rx_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) fifo_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push_i   (chr_push),
      .wdata_i  (chr_new),
      .pop_i    (rd_en_i),
      .rdata_o  (chr_head),
      .empty_o  (empty_o),
      .full_o   (full_o),
      .overrun_o(overrun_o)
   );

   assign rd_data_o    = chr_head.data;
   assign rd_frm_err_o = chr_head.frm_err;
   assign rd_par_err_o = chr_head.par_err;
   assign rd_brk_o     = chr_head.brk;
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic rd_en_i,
   input logic empty_o,
   input logic full_o,
   input logic overrun_o,
   input logic rd_frm_err_o,
   input logic rd_brk_o,
   input logic chr_push
);
   // R8: full and empty exclude each other
   a_r8_not_full_and_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(full_o && empty_o));

   // R8: without a read, a full queue stays full
   a_r8_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_o && !rd_en_i |=> full_o);

   // R9: overrun is sticky
   a_r9_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overrun_o |=> overrun_o);

   // R9: overrun only rises after the queue was full
   a_r9_overrun_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(overrun_o) |-> $past(full_o));

   // R6: a break entry also carries a framing error
   a_r6_break_has_framing: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !empty_o && rd_brk_o |-> rd_frm_err_o);

   // R10: a write alongside a read of a full queue keeps it full
   a_r10_push_pop_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_o && rd_en_i && chr_push |=> full_o);
endmodule

bind uart_rx_core uart_rx_core_chk chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .rd_en_i     (rd_en_i),
   .empty_o     (empty_o),
   .full_o      (full_o),
   .overrun_o   (overrun_o),
   .rd_frm_err_o(rd_frm_err_o),
   .rd_brk_o    (rd_brk_o),
   .chr_push    (chr_push)
);

// File: tb/uart_rx_core_tb_top.sv
`timescale 1ns/1ps
module uart_rx_core_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       tick = 1'b0;
   logic [1:0] wl = 2'd3;
   logic       pen = 1'b0;
   logic       podd = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       frm, perr, brk, empty, full, ovr;

   int n_run = 0;
   int n_fail = 0;
   int div = 3;
   bit done = 1'b0;

   always #2 clk = ~clk;

   uart_rx_core dut_i (
      .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .baud16_en_i(tick),
      .word_len_i(wl), .par_en_i(pen), .par_odd_i(podd), .rd_en_i(rd_en),
      .rd_data_o(rd_data), .rd_frm_err_o(frm), .rd_par_err_o(perr),
      .rd_brk_o(brk), .empty_o(empty), .full_o(full), .overrun_o(ovr)
   );

   initial begin : tick_gen
      int tc;
      tc = 0;
      forever begin
         @(negedge clk);
         tc = (tc >= div - 1) ? 0 : tc + 1;
         tick = (tc == 0);
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] d, input int nb, input bit has_p,
                       input bit pb, input bit stop, input int extra_low);
      int bc;
      bc = 16 * div;
      rxd = 1'b0;
      repeat (bc) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         rxd = d[i];
         repeat (bc) @(negedge clk);
      end
      if (has_p) begin
         rxd = pb;
         repeat (bc) @(negedge clk);
      end
      rxd = stop;
      repeat (bc) @(negedge clk);
      if (extra_low > 0) begin
         rxd = 1'b0;
         repeat (bc * extra_low) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (2 * bc) @(negedge clk);
   endtask

   task automatic pop(input string req, input int d, input bit f, input bit p, input bit b);
      @(negedge clk);
      chk({req, " nonempty"}, int'(empty), 0);
      chk({req, " data"}, int'(rd_data), d);
      chk({req, " frm"}, int'(frm), int'(f));
      chk({req, " par"}, int'(perr), int'(p));
      chk({req, " brk"}, int'(brk), int'(b));
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 empty", int'(empty), 1);
      chk("R1 full", int'(full), 0);
      chk("R1 overrun", int'(ovr), 0);
   endtask

   task automatic t_basic();
      div = 3; wl = 2'd3; pen = 1'b0;
      send(8'hA5, 8, 0, 0, 1, 0);
      pop("R3 8bit A5", 8'hA5, 0, 0, 0);
      send(8'h3C, 8, 0, 0, 1, 0);
      send(8'h81, 8, 0, 0, 1, 0);
      pop("R8 order first", 8'h3C, 0, 0, 0);
      pop("R8 order second", 8'h81, 0, 0, 0);
      chk("R8 empty after drain", int'(empty), 1);
   endtask

   task automatic t_wordlen();
      div = 3; pen = 1'b0;
      wl = 2'd0;
      send(8'hF5, 5, 0, 0, 1, 0);
      pop("R3 5bit upper zero", 8'h15, 0, 0, 0);
      wl = 2'd2;
      send(8'h6B, 7, 0, 0, 1, 0);
      pop("R3 7bit", 8'h6B, 0, 0, 0);
      wl = 2'd3;
   endtask

   task automatic t_parity();
      div = 3; wl = 2'd3; pen = 1'b1;
      podd = 1'b0;
      send(8'h5B, 8, 1, ^8'h5B, 1, 0);
      pop("R4 even good", 8'h5B, 0, 0, 0);
      send(8'h5B, 8, 1, ~^8'h5B, 1, 0);
      pop("R4 even bad", 8'h5B, 0, 1, 0);
      podd = 1'b1;
      send(8'hC4, 8, 1, ~^8'hC4, 1, 0);
      pop("R4 odd good", 8'hC4, 0, 0, 0);
      pen = 1'b0; podd = 1'b0;
   endtask

   task automatic t_false_start();
      div = 3; wl = 2'd3; pen = 1'b0;
      rxd = 1'b0;
      repeat (4 * div) @(negedge clk);
      rxd = 1'b1;
      repeat (48 * div) @(negedge clk);
      chk("R2 false start ignored", int'(empty), 1);
      send(8'h77, 8, 0, 0, 1, 0);
      pop("R2 ready after false start", 8'h77, 0, 0, 0);
   endtask

   task automatic t_framing();
      div = 3; wl = 2'd3; pen = 1'b0;
      send(8'h33, 8, 0, 0, 0, 0);
      pop("R5 framing", 8'h33, 1, 0, 0);
      send(8'h00, 8, 0, 0, 0, 2);
      send(8'h42, 8, 0, 0, 1, 0);
      pop("R6 break", 8'h00, 1, 0, 1);
      pop("R7 next after line high", 8'h42, 0, 0, 0);
      chk("R7 no extra entry", int'(empty), 1);
   endtask

   task automatic t_coincide();
      int n;
      div = 1; wl = 2'd3; pen = 1'b0;
      repeat (4) @(negedge clk);
      n = 0;
      fork
         send(8'h11, 8, 0, 0, 1, 0);
         begin
            while (empty) begin @(negedge clk); n++; end
         end
      join
      pop("R10 calib", 8'h11, 0, 0, 0);
      for (int i = 0; i < 16; i++) send(8'h10 + 8'(i), 8, 0, 0, 1, 0);
      chk("R8 full at 16", int'(full), 1);
      fork
         send(8'hEE, 8, 0, 0, 1, 0);
         begin
            repeat (n - 1) @(negedge clk);
            chk("R10 head before read", int'(rd_data), 8'h10);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
         end
      join
      chk("R10 still full", int'(full), 1);
      chk("R10 no overrun", int'(ovr), 0);
      for (int i = 1; i < 16; i++) pop("R10 drain old", 8'h10 + i, 0, 0, 0);
      pop("R10 new kept last", 8'hEE, 0, 0, 0);
      chk("R10 empty", int'(empty), 1);
   endtask

   task automatic t_overrun();
      div = 1; wl = 2'd3; pen = 1'b0;
      for (int i = 0; i < 16; i++) send(8'h20 + 8'(i), 8, 0, 0, 1, 0);
      chk("R9 no overrun yet", int'(ovr), 0);
      send(8'h99, 8, 0, 0, 1, 0);
      chk("R9 overrun set", int'(ovr), 1);
      chk("R9 still full", int'(full), 1);
      for (int i = 0; i < 16; i++) pop("R9 old contents", 8'h20 + i, 0, 0, 0);
      chk("R9 lost char absent", int'(empty), 1);
      chk("R9 overrun sticky", int'(ovr), 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_basic();
      t_wordlen();
      t_parity();
      t_false_start();
      t_framing();
      t_coincide();
      t_overrun();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule